// File: doc/BRIEF.md
# Lockdown-aware cache maintenance engine

This block carries out cache maintenance on a small set-associative tag store in which every line holds a valid bit, a dirty bit, a lock bit and a tag. A command names an operation (clean, invalidate, or clean followed by invalidate) and a target. The target is one line picked by set and way, one line found by address lookup, or a walk over the whole cache in set-major order. Cleaning a dirty line raises a writeback request that carries the line's set, way and tag. The dirty bit is cleared only when that request is acknowledged. Data storage and the memory-side datapath stay outside the block.

Locked lines change what a command does. This is fixed at build time. Set/way and whole-cache commands follow one of two policies. Under skip, a locked line stays resident and a parameter decides whether it is still cleaned. Under abort, the engine stops and reports a lockdown fault code. Address commands follow one of three policies: treat locked lines like the others, skip invalidating them, or abort. Line state, including the lock bits, is written through a load port and can be read back through a read port. Software can therefore run whole-cache walks without first looking at the lock state.

Top module: `cmaint_engine`

## Requirements
- R1: After reset every line has valid, dirty and lock at 0. `cmdReady` is 1, and `done`, `abort`, `wbReq` and `faultCode` are 0.
- R2: A command is taken when `cmdValid` and `cmdReady` are both 1 on a clock edge. `cmdReady` is then 0 until the cycle in which `done` or `abort` pulses for one cycle. A set/way or address command with no writeback pulses `done` one edge after the accepting edge.
- R3: Cleaning a valid dirty line raises `wbReq` with the line's set, way and tag. These stay steady until `wbAck`, and the dirty bit clears on the acknowledge edge. Cleaning a non-dirty line raises no request.
- R4: Invalidating an unlocked line clears its valid and dirty bits. Clean-and-invalidate on a dirty unlocked line writes the line back first. Opcodes are clean=0, invalidate=1, clean-and-invalidate=2; targets are set/way=0, address=1, whole cache=2.
- R5: With set/way policy skip (0), set/way and whole-cache commands never clear the valid bit of a locked line. Lock bits change only through the load port.
- R6: With set/way policy skip, a locked dirty line is written back and its dirty bit cleared when `CLEAN_LOCKED`=1. It is left untouched when `CLEAN_LOCKED`=0.
- R7: With the abort policy, a command that reaches a line whose lock bit is set makes no change to that line. It pulses `abort` for one cycle with `faultCode`=`FAULT_CODE` (default 5'b10100) and with that line's set and way, and it does not pulse `done`.
- R8: The address policy sets how a locked hit line is handled: 0 treats it like any other line, 1 keeps it valid (cleaning it only if `CLEAN_LOCKED`=1), and 2 aborts as in R7.
- R9: When an address clean-and-invalidate is allowed to invalidate a locked dirty line, the valid bit stays 1 until the writeback is acknowledged. It clears on the acknowledge edge.
- R10: The address is {tag, set index}. An address that matches no valid way of its set completes with `done` one edge after acceptance, with no abort and no state change.
- R11: A whole-cache command visits set 0 way 0, then way 1, and so on set by set, taking one cycle per line that needs no writeback. Under abort it stops at the first locked line, and lines already visited keep their new state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Engine idle, command can be taken |
| cmdOp | input | 2 | Operation: 0 clean, 1 invalidate, 2 clean-and-invalidate |
| cmdTgt | input | 2 | Target: 0 set/way, 1 address, 2 whole cache |
| cmdSet | input | SET_W | Set index for set/way commands |
| cmdWay | input | WAY_W | Way index for set/way commands |
| cmdAddr | input | TAG_W+SET_W | Address {tag, set} for address commands |
| wbReq | output | 1 | Writeback request |
| wbSet | output | SET_W | Set of the line to write back |
| wbWay | output | WAY_W | Way of the line to write back |
| wbTag | output | TAG_W | Tag of the line to write back |
| wbAck | input | 1 | Writeback acknowledge |
| done | output | 1 | One-cycle pulse when a command completes |
| abort | output | 1 | One-cycle pulse when a command stops on a locked line |
| faultCode | output | FSC_W | Lockdown fault code while abort is 1, else 0 |
| abortSet | output | SET_W | Set of the line that caused the abort |
| abortWay | output | WAY_W | Way of the line that caused the abort |
| ldEn | input | 1 | Write one line's state directly |
| ldSet | input | SET_W | Set to load |
| ldWay | input | WAY_W | Way to load |
| ldValid | input | 1 | Valid bit to load |
| ldDirty | input | 1 | Dirty bit to load |
| ldLock | input | 1 | Lock bit to load |
| ldTag | input | TAG_W | Tag to load |
| rdSet | input | SET_W | Set to read back |
| rdWay | input | WAY_W | Way to read back |
| rdValid | output | 1 | Valid bit of the line read back |
| rdDirty | output | 1 | Dirty bit of the line read back |
| rdLock | output | 1 | Lock bit of the line read back |
| rdTag | output | TAG_W | Tag of the line read back |

## Verification
Every result is due a fixed number of edges after the accepting edge. A set/way command, or an address command without writeback, gives `done` or `abort` after one edge. A walk takes one edge per visited line. A walk that aborts at line k, counted from zero, reports after k+1 edges. Each writeback adds one edge for the request, plus the edges the responder waits before it acknowledges, plus the acknowledge edge. The bench drives on falling edges, counts rising edges from acceptance, and samples `done`, `abort`, `cmdReady` and the read-back port at falling edges. It compares the edge count at which each pulse appears with the count worked out from these rules.

// File: rtl/cmaint_pkg.sv
package cmaint_pkg;

  typedef enum logic [1:0] {
    OP_CLEAN  = 2'd0,
    OP_INV    = 2'd1,
    OP_CLNINV = 2'd2
  } opKind_t;

  typedef enum logic [1:0] {
    TGT_SETWAY = 2'd0,
    TGT_ADDR   = 2'd1,
    TGT_WHOLE  = 2'd2
  } tgtKind_t;

  // set/way and whole-cache lock policies
  localparam int SW_SKIP  = 0;
  localparam int SW_ABORT = 1;
  // address-targeted lock policies
  localparam int AD_INVAL = 0;
  localparam int AD_SKIP  = 1;
  localparam int AD_ABORT = 2;

  typedef struct packed {
    logic clrDirty;
    logic clrValid;
  } lineStrobe_t;

endpackage

// File: rtl/cmaint_store.sv
module cmaint_store
  import cmaint_pkg::*;
#(
  parameter int NUM_SETS = 4,
  parameter int NUM_WAYS = 2,
  parameter int TAG_W    = 8,
  parameter int SET_W    = $clog2(NUM_SETS),
  parameter int WAY_W    = $clog2(NUM_WAYS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ldEn,
  input  logic [SET_W-1:0] ldSet,
  input  logic [WAY_W-1:0] ldWay,
  input  logic             ldValid,
  input  logic             ldDirty,
  input  logic             ldLock,
  input  logic [TAG_W-1:0] ldTag,
  input  logic [SET_W-1:0] rdSet,
  input  logic [WAY_W-1:0] rdWay,
  output logic             rdValid,
  output logic             rdDirty,
  output logic             rdLock,
  output logic [TAG_W-1:0] rdTag,
  input  logic [SET_W-1:0] lineSet,
  input  logic [WAY_W-1:0] lineWay,
  input  lineStrobe_t      strobe,
  output logic             lineValid,
  output logic             lineDirty,
  output logic             lineLock,
  output logic [TAG_W-1:0] lineTag,
  input  logic [SET_W-1:0] lookSet,
  input  logic [TAG_W-1:0] lookTag,
  output logic             hit,
  output logic [WAY_W-1:0] hitWay
);

  logic [NUM_SETS-1:0][NUM_WAYS-1:0] validQ, dirtyQ, lockQ;
  logic [TAG_W-1:0] tagQ [NUM_SETS][NUM_WAYS];
  logic [NUM_WAYS-1:0] match;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      dirtyQ <= '0;
      lockQ  <= '0;
      for (int s = 0; s < NUM_SETS; s++)
        for (int w = 0; w < NUM_WAYS; w++)
          tagQ[s][w] <= '0;
    end else begin
      if (ldEn) begin
        validQ[ldSet][ldWay] <= ldValid;
        dirtyQ[ldSet][ldWay] <= ldDirty;
        lockQ[ldSet][ldWay]  <= ldLock;
        tagQ[ldSet][ldWay]   <= ldTag;
      end
      if (strobe.clrDirty) dirtyQ[lineSet][lineWay] <= 1'b0;
      if (strobe.clrValid) begin
        validQ[lineSet][lineWay] <= 1'b0;
        dirtyQ[lineSet][lineWay] <= 1'b0;
      end
    end
  end

  assign rdValid   = validQ[rdSet][rdWay];
  assign rdDirty   = dirtyQ[rdSet][rdWay];
  assign rdLock    = lockQ[rdSet][rdWay];
  assign rdTag     = tagQ[rdSet][rdWay];
  assign lineValid = validQ[lineSet][lineWay];
  assign lineDirty = dirtyQ[lineSet][lineWay];
  assign lineLock  = lockQ[lineSet][lineWay];
  assign lineTag   = tagQ[lineSet][lineWay];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign match[w] = validQ[lookSet][w] && (tagQ[lookSet][w] == lookTag);
  end

  always_comb begin
    hitWay = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--)
      if (match[w]) hitWay = WAY_W'(w);
  end
  assign hit = |match;

  AST_LOCK_ONLY_BY_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !ldEn |=> $stable(lockQ)); // R5

endmodule

// File: rtl/cmaint_ctrl.sv
module cmaint_ctrl
  import cmaint_pkg::*;
#(
  parameter int NUM_SETS     = 4,
  parameter int NUM_WAYS     = 2,
  parameter int TAG_W        = 8,
  parameter int SET_W        = $clog2(NUM_SETS),
  parameter int WAY_W        = $clog2(NUM_WAYS),
  parameter int SW_POL       = SW_SKIP,
  parameter bit CLEAN_LOCKED = 1'b0,
  parameter int ADDR_POL     = AD_INVAL,
  parameter int FSC_W        = 5,
  parameter logic [FSC_W-1:0] FAULT_CODE = 5'b10100
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cmdValid,
  output logic                   cmdReady,
  input  logic [1:0]             cmdOp,
  input  logic [1:0]             cmdTgt,
  input  logic [SET_W-1:0]       cmdSet,
  input  logic [WAY_W-1:0]       cmdWay,
  input  logic [TAG_W+SET_W-1:0] cmdAddr,
  output logic [SET_W-1:0]       lineSet,
  output logic [WAY_W-1:0]       lineWay,
  output lineStrobe_t            strobe,
  input  logic                   lineValid,
  input  logic                   lineDirty,
  input  logic                   lineLock,
  input  logic [TAG_W-1:0]       lineTag,
  output logic [SET_W-1:0]       lookSet,
  output logic [TAG_W-1:0]       lookTag,
  input  logic                   hit,
  input  logic [WAY_W-1:0]       hitWay,
  output logic                   wbReq,
  output logic [SET_W-1:0]       wbSet,
  output logic [WAY_W-1:0]       wbWay,
  output logic [TAG_W-1:0]       wbTag,
  input  logic                   wbAck,
  output logic                   done,
  output logic                   abort,
  output logic [FSC_W-1:0]       faultCode,
  output logic [SET_W-1:0]       abortSet,
  output logic [WAY_W-1:0]       abortWay
);

  localparam int ADDR_W = TAG_W + SET_W;
  localparam logic [SET_W-1:0] LAST_SET = SET_W'(NUM_SETS - 1);
  localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(NUM_WAYS - 1);

  typedef enum logic [1:0] {S_IDLE, S_EVAL, S_WB} state_t;

  state_t           stateQ;
  logic [1:0]       opQ, tgtQ;
  logic [SET_W-1:0] curSetQ;
  logic [WAY_W-1:0] curWayQ;
  logic [TAG_W-1:0] tagQ;
  logic             invPendQ, doneQ, abortQ;

  logic [WAY_W-1:0] effWay;
  logic isAddr, polAbort, polSkip, skipLocked, miss, doAbort;
  logic wantClean, wantInv, lastLine, step, finish, abortNow, goWb;

  always_comb begin
    isAddr   = (tgtQ == TGT_ADDR);
    effWay   = (stateQ == S_EVAL && isAddr) ? hitWay : curWayQ;
    polAbort = isAddr ? (ADDR_POL == AD_ABORT) : (SW_POL == SW_ABORT);
    polSkip  = isAddr ? (ADDR_POL == AD_SKIP) : (SW_POL == SW_SKIP);
    skipLocked = lineLock && polSkip;
    miss     = isAddr && !hit;
    doAbort  = lineLock && polAbort;
    wantClean = (opQ != OP_INV) && lineValid && lineDirty && !(skipLocked && !CLEAN_LOCKED);
    wantInv  = (opQ != OP_CLEAN) && !skipLocked;
    lastLine = (tgtQ != TGT_WHOLE) || (curSetQ == LAST_SET && curWayQ == LAST_WAY);
    strobe   = '0;
    step     = 1'b0;
    finish   = 1'b0;
    abortNow = 1'b0;
    goWb     = 1'b0;
    case (stateQ)
      S_EVAL: begin
        if (miss)            finish   = 1'b1;
        else if (doAbort)    abortNow = 1'b1;
        else if (wantClean)  goWb     = 1'b1;
        else begin
          strobe.clrValid = wantInv;
          step = 1'b1;
        end
      end
      S_WB: begin
        if (wbAck) begin
          strobe.clrDirty = 1'b1;
          strobe.clrValid = invPendQ;
          step = 1'b1;
        end
      end
      default: ;
    endcase
    if (step && lastLine) finish = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= S_IDLE;
      opQ      <= '0;
      tgtQ     <= '0;
      curSetQ  <= '0;
      curWayQ  <= '0;
      tagQ     <= '0;
      invPendQ <= 1'b0;
      doneQ    <= 1'b0;
      abortQ   <= 1'b0;
      abortSet <= '0;
      abortWay <= '0;
    end else begin
      doneQ  <= finish;
      abortQ <= abortNow;
      if (abortNow) begin
        abortSet <= curSetQ;
        abortWay <= effWay;
      end
      if (stateQ == S_IDLE) begin
        if (cmdValid) begin
          opQ     <= cmdOp;
          tgtQ    <= cmdTgt;
          tagQ    <= cmdAddr[ADDR_W-1:SET_W];
          curSetQ <= (cmdTgt == TGT_ADDR) ? cmdAddr[SET_W-1:0] :
                     (cmdTgt == TGT_WHOLE) ? '0 : cmdSet;
          curWayQ <= (cmdTgt == TGT_SETWAY) ? cmdWay : '0;
          stateQ  <= S_EVAL;
        end
      end else if (finish || abortNow) begin
        stateQ <= S_IDLE;
      end else if (goWb) begin
        stateQ   <= S_WB;
        curWayQ  <= effWay;
        invPendQ <= wantInv;
      end else if (step) begin
        stateQ <= S_EVAL;
        if (curWayQ == LAST_WAY) begin
          curWayQ <= '0;
          curSetQ <= curSetQ + 1'b1;
        end else begin
          curWayQ <= curWayQ + 1'b1;
        end
      end
    end
  end

  assign cmdReady  = (stateQ == S_IDLE);
  assign lineSet   = curSetQ;
  assign lineWay   = effWay;
  assign lookSet   = curSetQ;
  assign lookTag   = tagQ;
  assign wbReq     = (stateQ == S_WB);
  assign wbSet     = curSetQ;
  assign wbWay     = curWayQ;
  assign wbTag     = lineTag;
  assign done      = doneQ;
  assign abort     = abortQ;
  assign faultCode = abortQ ? FAULT_CODE : '0;

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> !cmdReady); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R2
  AST_DONE_OR_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    !(done && abort)); // R7
  AST_WB_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (wbReq && !wbAck) |=> (wbReq && $stable(wbSet) && $stable(wbWay) && $stable(wbTag))); // R3
  AST_VALID_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (wbReq && !wbAck) |=> lineValid); // R9

endmodule

// File: rtl/cmaint_engine.sv
module cmaint_engine
  import cmaint_pkg::*;
#(
  parameter int NUM_SETS         = 4,
  parameter int NUM_WAYS         = 2,
  parameter int TAG_W            = 8,
  parameter int SW_LOCK_POLICY   = SW_SKIP,
  parameter bit CLEAN_LOCKED     = 1'b0,
  parameter int ADDR_LOCK_POLICY = AD_INVAL,
  parameter int FSC_W            = 5,
  parameter logic [FSC_W-1:0] FAULT_CODE = 5'b10100,
  localparam int SET_W  = $clog2(NUM_SETS),
  localparam int WAY_W  = $clog2(NUM_WAYS),
  localparam int ADDR_W = TAG_W + SET_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [1:0]        cmdOp,
  input  logic [1:0]        cmdTgt,
  input  logic [SET_W-1:0]  cmdSet,
  input  logic [WAY_W-1:0]  cmdWay,
  input  logic [ADDR_W-1:0] cmdAddr,
  output logic              wbReq,
  output logic [SET_W-1:0]  wbSet,
  output logic [WAY_W-1:0]  wbWay,
  output logic [TAG_W-1:0]  wbTag,
  input  logic              wbAck,
  output logic              done,
  output logic              abort,
  output logic [FSC_W-1:0]  faultCode,
  output logic [SET_W-1:0]  abortSet,
  output logic [WAY_W-1:0]  abortWay,
  input  logic              ldEn,
  input  logic [SET_W-1:0]  ldSet,
  input  logic [WAY_W-1:0]  ldWay,
  input  logic              ldValid,
  input  logic              ldDirty,
  input  logic              ldLock,
  input  logic [TAG_W-1:0]  ldTag,
  input  logic [SET_W-1:0]  rdSet,
  input  logic [WAY_W-1:0]  rdWay,
  output logic              rdValid,
  output logic              rdDirty,
  output logic              rdLock,
  output logic [TAG_W-1:0]  rdTag
);

  logic [SET_W-1:0] lineSet, lookSet;
  logic [WAY_W-1:0] lineWay, hitWay;
  logic [TAG_W-1:0] lineTag, lookTag;
  logic             lineValid, lineDirty, lineLock, hit;
  lineStrobe_t      strobe;

  cmaint_store #(
    .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W),
    .SET_W(SET_W), .WAY_W(WAY_W)
  ) store_i (
    .clk(clk), .rstN(rstN),
    .ldEn(ldEn), .ldSet(ldSet), .ldWay(ldWay), .ldValid(ldValid),
    .ldDirty(ldDirty), .ldLock(ldLock), .ldTag(ldTag),
    .rdSet(rdSet), .rdWay(rdWay), .rdValid(rdValid), .rdDirty(rdDirty),
    .rdLock(rdLock), .rdTag(rdTag),
    .lineSet(lineSet), .lineWay(lineWay), .strobe(strobe),
    .lineValid(lineValid), .lineDirty(lineDirty), .lineLock(lineLock), .lineTag(lineTag),
    .lookSet(lookSet), .lookTag(lookTag), .hit(hit), .hitWay(hitWay)
  );

  cmaint_ctrl #(
    .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W),
    .SET_W(SET_W), .WAY_W(WAY_W),
    .SW_POL(SW_LOCK_POLICY), .CLEAN_LOCKED(CLEAN_LOCKED), .ADDR_POL(ADDR_LOCK_POLICY),
    .FSC_W(FSC_W), .FAULT_CODE(FAULT_CODE)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOp(cmdOp), .cmdTgt(cmdTgt),
    .cmdSet(cmdSet), .cmdWay(cmdWay), .cmdAddr(cmdAddr),
    .lineSet(lineSet), .lineWay(lineWay), .strobe(strobe),
    .lineValid(lineValid), .lineDirty(lineDirty), .lineLock(lineLock), .lineTag(lineTag),
    .lookSet(lookSet), .lookTag(lookTag), .hit(hit), .hitWay(hitWay),
    .wbReq(wbReq), .wbSet(wbSet), .wbWay(wbWay), .wbTag(wbTag), .wbAck(wbAck),
    .done(done), .abort(abort), .faultCode(faultCode),
    .abortSet(abortSet), .abortWay(abortWay)
  );

endmodule

// File: tb/cmaint_engine_tb_top.sv
module cmaint_engine_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NI      = 3;
  localparam int ACK_DLY = 2;
  localparam int TW      = 8;
  localparam int SW      = 2;
  localparam int WW      = 1;
  localparam int AW      = TW + SW;
  localparam logic [4:0] FSC = 5'b10100;
  // instance 0: sw skip + clean locked, addr invalidate
  // instance 1: sw skip, no clean of locked, addr skip
  // instance 2: sw abort, addr abort
  localparam int SWP[NI] = '{0, 0, 1};
  localparam bit CLK[NI] = '{1'b1, 1'b0, 1'b0};
  localparam int ADP[NI] = '{0, 1, 2};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = '0, cmdTgt = '0;
  logic [SW-1:0] cmdSet = '0;
  logic [WW-1:0] cmdWay = '0;
  logic [AW-1:0] cmdAddr = '0;
  logic ldEn = 1'b0, ldValid = 1'b0, ldDirty = 1'b0, ldLock = 1'b0;
  logic [SW-1:0] ldSet = '0, rdSet = '0;
  logic [WW-1:0] ldWay = '0, rdWay = '0;
  logic [TW-1:0] ldTag = '0;

  wire [NI-1:0] readyV, wbReqV, doneV, abortV, rdValidV, rdDirtyV, rdLockV;
  wire [NI-1:0][SW-1:0] abSetV;
  wire [NI-1:0][WW-1:0] abWayV;
  wire [NI-1:0][4:0] fscV;
  wire [NI-1:0][TW-1:0] rdTagV, wbTagLastV;
  wire [NI-1:0][31:0] wbCntV;

  int nChecks = 0;
  int nFail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  for (genvar g = 0; g < NI; g++) begin : dut_g
    logic wbAck = 1'b0;
    int dly = 0;
    int cnt = 0;
    logic [TW-1:0] tagLast = '0;
    logic wbReq;
    logic [SW-1:0] wbSet;
    logic [WW-1:0] wbWay;
    logic [TW-1:0] wbTag;

    cmaint_engine #(
      .NUM_SETS(4), .NUM_WAYS(2), .TAG_W(TW),
      .SW_LOCK_POLICY(SWP[g]), .CLEAN_LOCKED(CLK[g]), .ADDR_LOCK_POLICY(ADP[g]),
      .FSC_W(5), .FAULT_CODE(FSC)
    ) dut_i (
      .clk(clk), .rstN(rstN),
      .cmdValid(cmdValid), .cmdReady(readyV[g]), .cmdOp(cmdOp), .cmdTgt(cmdTgt),
      .cmdSet(cmdSet), .cmdWay(cmdWay), .cmdAddr(cmdAddr),
      .wbReq(wbReq), .wbSet(wbSet), .wbWay(wbWay), .wbTag(wbTag), .wbAck(wbAck),
      .done(doneV[g]), .abort(abortV[g]), .faultCode(fscV[g]),
      .abortSet(abSetV[g]), .abortWay(abWayV[g]),
      .ldEn(ldEn), .ldSet(ldSet), .ldWay(ldWay), .ldValid(ldValid),
      .ldDirty(ldDirty), .ldLock(ldLock), .ldTag(ldTag),
      .rdSet(rdSet), .rdWay(rdWay), .rdValid(rdValidV[g]), .rdDirty(rdDirtyV[g]),
      .rdLock(rdLockV[g]), .rdTag(rdTagV[g])
    );

    assign wbReqV[g] = wbReq;
    assign wbCntV[g] = cnt;
    assign wbTagLastV[g] = tagLast;

    // writeback responder: acknowledges ACK_DLY falling edges after the request
    always @(negedge clk) begin
      if (!rstN) begin
        wbAck = 1'b0;
        dly = 0;
      end else if (wbAck) begin
        wbAck = 1'b0;
      end else if (wbReq) begin
        if (dly == ACK_DLY) begin
          wbAck = 1'b1;
          dly = 0;
          cnt = cnt + 1;
          tagLast = wbTag;
        end else begin
          dly = dly + 1;
        end
      end
    end
  end

  // per-command observations
  bit dSeen[NI], aSeen[NI];
  int latV[NI], wbDelta[NI];
  logic [4:0] fscSeen[NI];
  logic [SW-1:0] abSSeen[NI];
  logic [WW-1:0] abWSeen[NI];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chkEq(input string req, input string what, input int act, input int exp);
    chk(act == exp, req, what, act, exp);
  endtask

  task automatic loadLine(input int s, input int w, input bit v, input bit d, input bit l, input int tag);
    @(negedge clk);
    ldEn = 1'b1; ldSet = SW'(s); ldWay = WW'(w);
    ldValid = v; ldDirty = d; ldLock = l; ldTag = TW'(tag);
    @(negedge clk);
    ldEn = 1'b0;
  endtask

  task automatic readAt(input int s, input int w);
    rdSet = SW'(s); rdWay = WW'(w);
    #1;
  endtask

  task automatic runCmd(input int op, input int tgt, input int s, input int w, input int addr);
    int base[NI];
    int cnt;
    bit all;
    for (int i = 0; i < NI; i++) begin
      base[i] = wbCntV[i];
      dSeen[i] = 1'b0; aSeen[i] = 1'b0; latV[i] = -1;
      fscSeen[i] = '0; abSSeen[i] = '0; abWSeen[i] = '0;
    end
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 2'(op); cmdTgt = 2'(tgt);
    cmdSet = SW'(s); cmdWay = WW'(w); cmdAddr = AW'(addr);
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    cnt = 0;
    all = 1'b0;
    while (!all && cnt < 300) begin
      all = 1'b1;
      for (int i = 0; i < NI; i++) begin
        if (cnt == 0) chkEq("R2", "ready low after accept", readyV[i], 0);
        if (!dSeen[i] && !aSeen[i]) begin
          if (doneV[i] || abortV[i]) begin
            latV[i] = cnt;
            chkEq("R2", "ready with completion", readyV[i], 1);
            if (doneV[i]) dSeen[i] = 1'b1;
            if (abortV[i]) begin
              aSeen[i] = 1'b1;
              fscSeen[i] = fscV[i];
              abSSeen[i] = abSetV[i];
              abWSeen[i] = abWayV[i];
            end
          end
        end
        if (!dSeen[i] && !aSeen[i]) all = 1'b0;
      end
      if (!all) begin
        @(posedge clk);
        @(negedge clk);
        cnt++;
      end
    end
    if (!all) chkEq("R2", "command completion", 0, 1);
    // one more cycle so any pulse would be seen as over
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < NI; i++) begin
      chkEq("R2", "done is a single pulse", doneV[i], 0);
      wbDelta[i] = wbCntV[i] - base[i];
    end
  endtask

  task automatic expDone(input int i, input int lat, input string req);
    chkEq(req, $sformatf("inst%0d done", i), dSeen[i], 1);
    chkEq(req, $sformatf("inst%0d no abort", i), aSeen[i], 0);
    chkEq(req, $sformatf("inst%0d latency", i), latV[i], lat);
  endtask

  task automatic expAbort(input int i, input int lat, input int s, input int w);
    chkEq("R7", $sformatf("inst%0d abort", i), aSeen[i], 1);
    chkEq("R7", $sformatf("inst%0d no done", i), dSeen[i], 0);
    chkEq("R7", $sformatf("inst%0d fault code", i), fscSeen[i], FSC);
    chkEq("R7", $sformatf("inst%0d abort set", i), abSSeen[i], s);
    chkEq("R7", $sformatf("inst%0d abort way", i), abWSeen[i], w);
    chkEq("R11", $sformatf("inst%0d abort latency", i), latV[i], lat);
  endtask

  task automatic expLine(input int i, input int s, input int w, input bit v, input bit d, input string req);
    readAt(s, w);
    chkEq(req, $sformatf("inst%0d line %0d/%0d valid", i, s, w), rdValidV[i], v);
    chkEq(req, $sformatf("inst%0d line %0d/%0d dirty", i, s, w), rdDirtyV[i], d);
  endtask

  task automatic testReset();
    @(negedge clk);
    for (int i = 0; i < NI; i++) begin
      chkEq("R1", "ready after reset", readyV[i], 1);
      chkEq("R1", "done after reset", doneV[i], 0);
      chkEq("R1", "abort after reset", abortV[i], 0);
      chkEq("R1", "wbReq after reset", wbReqV[i], 0);
      chkEq("R1", "fault code after reset", fscV[i], 0);
      readAt(2, 1);
      chkEq("R1", "valid after reset", rdValidV[i], 0);
      chkEq("R1", "lock after reset", rdLockV[i], 0);
    end
  endtask

  task automatic testSwInv();
    loadLine(2, 1, 1, 1, 0, 8'h21);
    runCmd(1, 0, 2, 1, 0);
    for (int i = 0; i < NI; i++) begin
      expDone(i, 1, "R4");
      chkEq("R4", "no writeback on invalidate", wbDelta[i], 0);
      expLine(i, 2, 1, 0, 0, "R4");
    end
  endtask

  task automatic testSwClean();
    loadLine(0, 1, 1, 1, 0, 8'h33);
    loadLine(2, 0, 1, 0, 0, 8'h44);
    runCmd(0, 0, 0, 1, 0);
    for (int i = 0; i < NI; i++) begin
      expDone(i, ACK_DLY + 2, "R3");
      chkEq("R3", "one writeback", wbDelta[i], 1);
      chkEq("R3", "writeback tag", wbTagLastV[i], 8'h33);
      expLine(i, 0, 1, 1, 0, "R3");
    end
    runCmd(0, 0, 2, 0, 0);
    for (int i = 0; i < NI; i++) begin
      expDone(i, 1, "R3");
      chkEq("R3", "clean line no writeback", wbDelta[i], 0);
      expLine(i, 2, 0, 1, 0, "R3");
    end
    // clean-and-invalidate of a dirty unlocked line: written back then dropped
    loadLine(0, 1, 1, 1, 0, 8'h35);
    runCmd(2, 0, 0, 1, 0);
    for (int i = 0; i < NI; i++) begin
      expDone(i, ACK_DLY + 2, "R4");
      chkEq("R4", "CI writes back", wbDelta[i], 1);
      expLine(i, 0, 1, 0, 0, "R4");
    end
  endtask

  task automatic testSwLockInv();
    loadLine(1, 0, 1, 0, 1, 8'h10);
    runCmd(1, 0, 1, 0, 0);
    for (int i = 0; i < 2; i++) begin
      expDone(i, 1, "R5");
      expLine(i, 1, 0, 1, 0, "R5");
    end
    expAbort(2, 1, 1, 0);
    expLine(2, 1, 0, 1, 0, "R7");
    readAt(1, 0);
    for (int i = 0; i < NI; i++) chkEq("R5", "lock bit kept", rdLockV[i], 1);
  endtask

  task automatic testSwLockClean();
    loadLine(1, 0, 1, 1, 1, 8'h11);
    runCmd(2, 0, 1, 0, 0);
    expDone(0, ACK_DLY + 2, "R6");
    chkEq("R6", "inst0 locked line cleaned", wbDelta[0], 1);
    expLine(0, 1, 0, 1, 0, "R6");
    expDone(1, 1, "R6");
    chkEq("R6", "inst1 locked line not cleaned", wbDelta[1], 0);
    expLine(1, 1, 0, 1, 1, "R6");
    expAbort(2, 1, 1, 0);
    chkEq("R7", "inst2 no writeback", wbDelta[2], 0);
    expLine(2, 1, 0, 1, 1, "R7");
  endtask

  task automatic testAddrLock();
    loadLine(3, 0, 1, 0, 0, 8'h5B);
    loadLine(3, 1, 1, 1, 1, 8'h5A);
    runCmd(2, 1, 0, 0, {8'h5A, 2'd3});
    expDone(0, ACK_DLY + 2, "R9");
    chkEq("R9", "inst0 writeback before invalidate", wbDelta[0], 1);
    chkEq("R9", "inst0 writeback tag", wbTagLastV[0], 8'h5A);
    expLine(0, 3, 1, 0, 0, "R8");
    expDone(1, 1, "R8");
    chkEq("R8", "inst1 skip no writeback", wbDelta[1], 0);
    expLine(1, 3, 1, 1, 1, "R8");
    expAbort(2, 1, 3, 1);
    expLine(2, 3, 1, 1, 1, "R8");
    for (int i = 0; i < NI; i++) expLine(i, 3, 0, 1, 0, "R8");
  endtask

  task automatic testAddrMiss();
    loadLine(3, 0, 1, 1, 1, 8'h5B);
    runCmd(2, 1, 0, 0, {8'h77, 2'd3});
    for (int i = 0; i < NI; i++) begin
      expDone(i, 1, "R10");
      chkEq("R10", "miss no writeback", wbDelta[i], 0);
      expLine(i, 3, 0, 1, 1, "R10");
    end
  endtask

  task automatic testWalk();
    for (int k = 0; k < 8; k++)
      loadLine(k / 2, k % 2, 1, 0, (k == 3 || k == 6), 8'h40 + k);
    runCmd(1, 2, 0, 0, 0);
    for (int i = 0; i < 2; i++) begin
      expDone(i, 8, "R11");
      for (int k = 0; k < 8; k++) expLine(i, k / 2, k % 2, (k == 3 || k == 6), 0, "R5");
    end
    expAbort(2, 4, 1, 1);
    for (int k = 0; k < 8; k++) expLine(2, k / 2, k % 2, (k >= 3), 0, "R11");
  endtask

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testSwInv();
    testSwClean();
    testSwLockInv();
    testSwLockClean();
    testAddrLock();
    testAddrMiss();
    testWalk();
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    chkEq("R2", "watchdog expired", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule